// File: doc/BRIEF.md
# Cascadable Pulse Accumulator Bank

This block holds four 8-bit pulse accumulators. Each accumulator counts edges on its own input pin. Each input passes through a two-flop synchroniser, and a per-channel setting chooses whether rising or falling edges count. Channels 0 and 1 can be joined into one 16-bit accumulator. Channel 0 is the low byte, and channel 1 then advances only on a carry out of channel 0.

A single overflow flag records a wrap of channel 1. In joined mode this is the wrap of the 16-bit pair. In separate mode it is the 8-bit wrap of channel 1 alone. Software can clear the flag in two ways: by writing a one to its bit, or, when fast-clear is on, by any access to either counter of the pair.

A one-cycle latch strobe, for example an underflow pulse from a neighbouring modulus counter, copies every enabled counter into its own read-only holding register in the same clock.

Register access uses a byte-wide bus with an address, a select and a write strobe. Read data is combinational from the address.

Register map (byte addresses):

| Address | Contents | Access |
|---|---|---|
| 0 to 3 | counter of channel i | read/write |
| 4 to 7 | holding register of channel i | read-only |
| 8 to 11 | config of channel i: bit0 count enable, bit1 edge select (0 = rising, 1 = falling) | read/write |
| 12 | mode: bit0 joins channels 0 and 1, bit1 fast-clear, bit2 interrupt enable | read/write |
| 13 | latch enables: bit i enables capture for channel i | read/write |
| 14 | flag register: bit1 is the overflow flag | read, write-one-to-clear |

Top module: `pulse_acc_bank`

## Requirements
- R1: After reset every counter, holding register, config, mode, latch-enable and flag reads 0x00, and irq is low.
- R2: An enabled channel adds one for each selected edge of its pin. Rising is selected when config bit1 is 0 and falling when it is 1. The new count is visible after the third rising clock edge that follows the pin change. A channel whose config bit0 is 0 does not count.
- R3: With mode bit0 set, channel 1 ignores its pin and adds one only when channel 0 wraps from 0xFF to 0x00 on a counted edge.
- R4: With mode bit0 set, the wrap of the pair from 0xFFFF to 0x0000 sets the overflow flag, which reads as 0x02 at address 14.
- R5: With mode bit0 clear, an 8-bit wrap of channel 1 from 0xFF to 0x00 sets the overflow flag. Wraps of channels 0, 2 and 3 leave the flag unchanged.
- R6: A write to address 14 with data bit1 set clears the flag. A write with bit1 clear leaves the flag unchanged.
- R7: With mode bit1 set, any read or write access to address 0 or 1 clears the flag. An access to any other address does not clear it, and with mode bit1 clear counter accesses do not clear it.
- R8: If a clear request and an overflow wrap fall in the same cycle, the flag ends set.
- R9: In the cycle latch_stb is high, each channel whose latch-enable bit is set copies its counter into its holding register. Holding registers of channels whose bit is clear keep their value.
- R10: Bus writes to addresses 4 to 7 leave the holding registers unchanged.
- R11: irq is high exactly when the overflow flag and mode bit2 are both set.
- R12: A bus write to a counter loads the written value. It wins over an edge that would count in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| pin_in | input | 4 | edge inputs, one per channel, asynchronous |
| latch_stb | input | 1 | one-cycle capture strobe for holding registers |
| bus_sel | input | 1 | register access in this cycle |
| bus_wr | input | 1 | access is a write when high |
| bus_addr | input | 4 | register address |
| bus_wdata | input | 8 | write data |
| bus_rdata | output | 8 | read data for bus_addr |
| irq | output | 1 | overflow interrupt request |

## Verification
The assertions assume that the pins stay still for at least two clocks between changes, so that every change becomes one clean edge after the synchroniser. They also assume that bus_wr only means something while bus_sel is high, and that latch_stb is a single-cycle pulse. The bench holds each pin level for four clocks. It drives the bus for exactly one cycle per access, and pulses the strobe for one cycle. Where it must make an edge meet a bus write in the same clock, it counts the synchroniser delay to place the write.

// File: rtl/pa_pkg.sv
package pa_pkg;
  localparam int PA_W = 8;

  // Incremented value with the carry out in the top bit.
  function automatic logic [PA_W:0] step_cnt(input logic [PA_W-1:0] v);
    return {1'b0, v} + {{PA_W{1'b0}}, 1'b1};
  endfunction

  // Edge detection on a synchronised level; fall selects the falling edge.
  function automatic logic edge_hit(input logic fall, input logic prev, input logic cur);
    return fall ? (prev & ~cur) : (cur & ~prev);
  endfunction
endpackage

// File: rtl/pa_edge_sync.sv
module pa_edge_sync #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] pin,
  input  logic [NCH-1:0] en,
  input  logic [NCH-1:0] fall,
  output logic [NCH-1:0] evt
);
  import pa_pkg::*;

  for (genvar i = 0; i < NCH; i++) begin : g_sync
    logic s1, s2, pv;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= 1'b0;
        s2 <= 1'b0;
        pv <= 1'b0;
      end else begin
        s1 <= pin[i];
        s2 <= s1;
        pv <= s2;
      end
    end
    assign evt[i] = en[i] & edge_hit(fall[i], pv, s2);
  end
endmodule

// File: rtl/pa_counters.sv
module pa_counters #(
  parameter int NCH = 4,
  parameter int W   = pa_pkg::PA_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] evt,
  input  logic           cascade,
  input  logic [NCH-1:0] wr_en,
  input  logic [W-1:0]   wdata,
  output logic [NCH*W-1:0] cnt_flat,
  output logic           carry0,
  output logic           wrap16,
  output logic           wrap8
);
  import pa_pkg::*;

  logic [NCH-1:0] full;
  logic [NCH-1:0] inc;
  logic           up_go;

  assign carry0 = evt[0] & ~wr_en[0] & full[0];

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [W-1:0] q;
    logic [W:0]   nxt;
    assign nxt     = step_cnt(q);
    assign full[i] = nxt[W];
    if (i == 1) begin : g_upper
      assign inc[i] = cascade ? carry0 : evt[i];
    end else begin : g_plain
      assign inc[i] = evt[i];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        q <= '0;
      else if (wr_en[i]) q <= wdata;
      else if (inc[i])   q <= nxt[W-1:0];
    end
    assign cnt_flat[i*W +: W] = q;
  end

  assign up_go  = inc[1] & ~wr_en[1];
  assign wrap16 = cascade  & up_go & full[1];
  assign wrap8  = ~cascade & up_go & full[1];
endmodule

// File: rtl/pa_hold.sv
module pa_hold #(
  parameter int NCH = 4,
  parameter int W   = pa_pkg::PA_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strobe,
  input  logic [NCH-1:0]   lat_en,
  input  logic [NCH*W-1:0] cnt_flat,
  output logic [NCH*W-1:0] hold_flat
);
  for (genvar i = 0; i < NCH; i++) begin : g_hold
    logic [W-1:0] h;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    h <= '0;
      else if (strobe && lat_en[i])  h <= cnt_flat[i*W +: W];
    end
    assign hold_flat[i*W +: W] = h;
  end
endmodule

// File: rtl/pulse_acc_bank.sv
module pulse_acc_bank #(
  parameter int NCH = 4,
  parameter int W   = pa_pkg::PA_W,
  parameter int AW  = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] pin_in,
  input  logic           latch_stb,
  input  logic           bus_sel,
  input  logic           bus_wr,
  input  logic [AW-1:0]  bus_addr,
  input  logic [W-1:0]   bus_wdata,
  output logic [W-1:0]   bus_rdata,
  output logic           irq
);
  localparam int A_CNT   = 0;
  localparam int A_HOLD  = NCH;
  localparam int A_CFG   = 2 * NCH;
  localparam int A_MODE  = 3 * NCH;
  localparam int A_LATEN = 3 * NCH + 1;
  localparam int A_FLAG  = 3 * NCH + 2;

  logic [1:0]       cfg [NCH];
  logic [2:0]       mode;
  logic [NCH-1:0]   lat_en;
  logic             flag;
  logic [NCH-1:0]   ch_en, ch_fall, evt, cnt_wr;
  logic [NCH*W-1:0] cnt_flat, hold_flat;
  logic             carry0, wrap16, wrap8, ovf_evt;
  logic             bus_write, cascade, fast_clr, irq_en, flag_clr_req;

  assign bus_write = bus_sel & bus_wr;
  assign cascade   = mode[0];
  assign fast_clr  = mode[1];
  assign irq_en    = mode[2];

  for (genvar i = 0; i < NCH; i++) begin : g_dec
    assign ch_en[i]   = cfg[i][0];
    assign ch_fall[i] = cfg[i][1];
    assign cnt_wr[i]  = bus_write && (bus_addr == AW'(A_CNT + i));
  end

  pa_edge_sync #(.NCH(NCH)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin(pin_in), .en(ch_en), .fall(ch_fall), .evt(evt)
  );

  pa_counters #(.NCH(NCH), .W(W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .evt(evt), .cascade(cascade), .wr_en(cnt_wr),
    .wdata(bus_wdata), .cnt_flat(cnt_flat), .carry0(carry0),
    .wrap16(wrap16), .wrap8(wrap8)
  );

  pa_hold #(.NCH(NCH), .W(W)) u_hold (
    .clk(clk), .rst_n(rst_n), .strobe(latch_stb), .lat_en(lat_en),
    .cnt_flat(cnt_flat), .hold_flat(hold_flat)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) cfg[i] <= '0;
      mode   <= '0;
      lat_en <= '0;
    end else if (bus_write) begin
      for (int i = 0; i < NCH; i++)
        if (bus_addr == AW'(A_CFG + i)) cfg[i] <= bus_wdata[1:0];
      if (bus_addr == AW'(A_MODE))  mode   <= bus_wdata[2:0];
      if (bus_addr == AW'(A_LATEN)) lat_en <= bus_wdata[NCH-1:0];
    end
  end

  // Overflow flag: a wrap in the same cycle as a clear leaves it set.
  assign ovf_evt      = wrap16 | wrap8;
  assign flag_clr_req = (bus_write && bus_addr == AW'(A_FLAG) && bus_wdata[1])
                      | (fast_clr && bus_sel && bus_addr < AW'(2));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            flag <= 1'b0;
    else if (ovf_evt)      flag <= 1'b1;
    else if (flag_clr_req) flag <= 1'b0;
  end

  assign irq = flag & irq_en;

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NCH; i++) begin
      if (bus_addr == AW'(A_CNT + i))  bus_rdata = cnt_flat[i*W +: W];
      if (bus_addr == AW'(A_HOLD + i)) bus_rdata = hold_flat[i*W +: W];
      if (bus_addr == AW'(A_CFG + i))  bus_rdata = {{(W-2){1'b0}}, cfg[i]};
    end
    if (bus_addr == AW'(A_MODE))  bus_rdata = {{(W-3){1'b0}}, mode};
    if (bus_addr == AW'(A_LATEN)) bus_rdata = {{(W-NCH){1'b0}}, lat_en};
    if (bus_addr == AW'(A_FLAG))  bus_rdata = {{(W-2){1'b0}}, flag, 1'b0};
  end
endmodule

// File: rtl/pa_bank_chk.sv
module pa_bank_chk #(
  parameter int NCH = 4,
  parameter int W   = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wrap16,
  input logic             wrap8,
  input logic             flag,
  input logic             irq,
  input logic             irq_en,
  input logic             flag_clr_req,
  input logic             latch_stb,
  input logic [NCH*W-1:0] hold_flat,
  input logic             cascade,
  input logic             carry0,
  input logic             cnt1_wr,
  input logic [W-1:0]     cnt1
);
  p_wrap16_sets_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wrap16 |=> flag);

  p_wrap8_sets_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wrap8 |=> flag);

  p_flag_rise_from_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(wrap16 || wrap8));

  p_clear_request_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr_req && !wrap16 && !wrap8) |=> !flag);

  p_set_beats_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr_req && (wrap16 || wrap8)) |=> flag);

  p_irq_needs_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag || !irq_en) |-> !irq);

  p_hold_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_stb |=> $stable(hold_flat));

  p_upper_waits_carry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cascade && !carry0 && !cnt1_wr) |=> $stable(cnt1));
endmodule

bind pulse_acc_bank pa_bank_chk #(.NCH(NCH), .W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wrap16(wrap16), .wrap8(wrap8), .flag(flag),
  .irq(irq), .irq_en(irq_en), .flag_clr_req(flag_clr_req),
  .latch_stb(latch_stb), .hold_flat(hold_flat), .cascade(cascade),
  .carry0(carry0), .cnt1_wr(cnt_wr[1]), .cnt1(cnt_flat[2*W-1:W])
);

// File: tb/tb_pulse_acc_bank.sv
`timescale 1ns/1ps
module tb_pulse_acc_bank;
  localparam int PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] pin_in;
  logic       latch_stb, bus_sel, bus_wr;
  logic [3:0] bus_addr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic       irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  always #(PERIOD/2) clk = ~clk;

  pulse_acc_bank dut (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .latch_stb(latch_stb),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  // Behavioural reference state.
  int m_cnt[4], m_hold[4], m_cfg[4];
  int m_mode, m_laten, m_flag;
  bit s1[4], s2[4], pv[4];

  function automatic int mread(input int a);
    if (a < 4)   return m_cnt[a];
    if (a < 8)   return m_hold[a-4];
    if (a < 12)  return m_cfg[a-8];
    if (a == 12) return m_mode;
    if (a == 13) return m_laten;
    if (a == 14) return m_flag * 2;
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin
        m_cnt[i] = 0; m_hold[i] = 0; m_cfg[i] = 0;
        s1[i] = 0; s2[i] = 0; pv[i] = 0;
      end
      m_mode = 0; m_laten = 0; m_flag = 0;
    end else begin
      bit ev[4];
      bit w, carry, wrapped, clr, up;
      int a;
      w = bus_sel && bus_wr;
      a = int'(bus_addr);
      for (int i = 0; i < 4; i++) begin
        if ((m_cfg[i] & 1) == 0)      ev[i] = 0;
        else if ((m_cfg[i] & 2) != 0) ev[i] = pv[i] && !s2[i];
        else                          ev[i] = s2[i] && !pv[i];
      end
      if (latch_stb)
        for (int i = 0; i < 4; i++)
          if (((m_laten >> i) & 1) != 0) m_hold[i] = m_cnt[i];
      clr = (w && a == 14 && bus_wdata[1]) ||
            (((m_mode & 2) != 0) && bus_sel && a < 2);
      carry = 0; wrapped = 0;
      if (w && a == 0) m_cnt[0] = int'(bus_wdata);
      else if (ev[0]) begin
        if (m_cnt[0] == 255) begin carry = 1; m_cnt[0] = 0; end
        else m_cnt[0]++;
      end
      up = ((m_mode & 1) != 0) ? carry : ev[1];
      if (w && a == 1) m_cnt[1] = int'(bus_wdata);
      else if (up) begin
        if (m_cnt[1] == 255) begin wrapped = 1; m_cnt[1] = 0; end
        else m_cnt[1]++;
      end
      for (int i = 2; i < 4; i++) begin
        if (w && a == i) m_cnt[i] = int'(bus_wdata);
        else if (ev[i]) m_cnt[i] = (m_cnt[i] + 1) % 256;
      end
      if (wrapped) m_flag = 1;
      else if (clr) m_flag = 0;
      if (w && a >= 8 && a < 12) m_cfg[a-8] = int'(bus_wdata) & 3;
      if (w && a == 12) m_mode  = int'(bus_wdata) & 7;
      if (w && a == 13) m_laten = int'(bus_wdata) & 15;
      for (int i = 0; i < 4; i++) begin
        pv[i] = s2[i]; s2[i] = s1[i]; s1[i] = pin_in[i];
      end
    end
  end

  // R11 compared on every clock against the reference.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      n_cmp++;
      if (irq !== (m_flag == 1 && (m_mode & 4) != 0)) begin
        n_bad++;
        $display("FAIL R11 per-cycle irq: actual %0b expected %0b", irq,
                 (m_flag == 1 && (m_mode & 4) != 0));
      end
    end
  end

  task automatic bus_write(input int a, input int d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = 4'(a); bus_wdata = 8'(d);
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  // Read with check against an expected value and the reference.
  task automatic rdx(input int a, input int exp, input string tag);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = 4'(a);
    #1;
    n_cmp++;
    if (int'(bus_rdata) != exp || exp != mread(a)) begin
      n_bad++;
      $display("FAIL %s addr %0d: actual 0x%02h expected 0x%02h (model 0x%02h)",
               tag, a, bus_rdata, exp, mread(a));
    end
    @(negedge clk);
    bus_sel = 0;
  endtask

  task automatic chk_irq(input bit exp, input string tag);
    @(negedge clk); #1;
    n_cmp++;
    if (irq !== exp) begin
      n_bad++;
      $display("FAIL %s irq: actual %0b expected %0b", tag, irq, exp);
    end
  endtask

  task automatic pulse(input int ch);
    @(negedge clk); pin_in[ch] = 1'b1;
    repeat (4) @(negedge clk);
    pin_in[ch] = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic strobe();
    @(negedge clk); latch_stb = 1;
    @(negedge clk); latch_stb = 0;
  endtask

  initial begin
    rst_n = 0; pin_in = '0; latch_stb = 0; bus_sel = 0; bus_wr = 0;
    bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    for (int a = 0; a < 15; a++) rdx(a, 0, "R1 reset");
    chk_irq(0, "R1 reset");

    bus_write(8, 1); bus_write(9, 1); bus_write(10, 3);
    for (int k = 0; k < 5; k++) pulse(0);
    rdx(0, 5, "R2 rising count");
    for (int k = 0; k < 3; k++) pulse(2);
    rdx(2, 3, "R2 falling count");
    pulse(3); pulse(3);
    rdx(3, 0, "R2 disabled channel");

    bus_write(1, 8'hFE);
    rdx(1, 8'hFE, "R12 load");
    pulse(1);
    rdx(14, 0, "R5 before wrap");
    pulse(1);
    rdx(1, 0, "R5 upper wrapped");
    rdx(14, 2, "R5 8-bit wrap sets");
    bus_write(12, 4);
    chk_irq(1, "R11 enabled");

    bus_write(14, 8'hFD);
    rdx(14, 2, "R6 bit1 zero keeps");
    bus_write(14, 8'h02);
    rdx(14, 0, "R6 write-one clears");
    chk_irq(0, "R11 flag clear");

    bus_write(0, 8'hFF);
    pulse(0);
    rdx(0, 0, "R5 lower wrapped");
    rdx(14, 0, "R5 lower wrap no flag");

    bus_write(12, 5);
    bus_write(0, 8'hFF); bus_write(1, 8'hFF);
    pulse(0);
    rdx(0, 0, "R3 low byte");
    rdx(1, 0, "R3 high byte");
    rdx(14, 2, "R4 16-bit wrap");
    pulse(1);
    rdx(1, 0, "R3 upper pin ignored");
    pulse(0);
    rdx(0, 1, "R3 low counts");
    rdx(1, 0, "R3 no carry");

    rdx(14, 2, "R7 fast off keeps");
    bus_write(12, 7);
    rdx(2, 3, "R7 other address");
    rdx(14, 2, "R7 other address keeps");
    rdx(1, 0, "R7 pair access");
    rdx(14, 0, "R7 fast clear");

    // R8: clear write lands in the cycle the upper counter wraps.
    bus_write(12, 4);
    bus_write(1, 8'hFF);
    @(negedge clk); pin_in[1] = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = 4'd14; bus_wdata = 8'h02;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
    repeat (3) @(negedge clk);
    pin_in[1] = 1'b0;
    repeat (3) @(negedge clk);
    rdx(14, 2, "R8 set wins");
    chk_irq(1, "R11 after R8");

    bus_write(3, 8'h77); bus_write(1, 8'h33);
    bus_write(13, 8'h05);
    strobe();
    rdx(4, 1, "R9 ch0 captured");
    rdx(5, 0, "R9 ch1 not enabled");
    rdx(6, 3, "R9 ch2 captured");
    rdx(7, 0, "R9 ch3 not enabled");
    bus_write(13, 8'h0A);
    strobe();
    rdx(5, 8'h33, "R9 ch1 captured");
    rdx(7, 8'h77, "R9 ch3 captured");
    rdx(4, 1, "R9 ch0 kept");

    bus_write(4, 8'hAA);
    rdx(4, 1, "R10 write ignored");
    bus_write(6, 8'h55);
    rdx(6, 3, "R10 write ignored");

    // R12: write to ch2 in the cycle its falling edge would count.
    @(negedge clk); pin_in[2] = 1'b1;
    repeat (4) @(negedge clk);
    pin_in[2] = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = 4'd2; bus_wdata = 8'h40;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
    repeat (4) @(negedge clk);
    rdx(2, 8'h40, "R12 write wins");

    for (int a = 2; a < 15; a++) rdx(a, mread(a), "R1 final state");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule